// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block collects interrupt requests from a set of external lines and turns them into interrupt messages, one at a time. Each line has a redirection entry that software programs through an indexed register port. The entry gives the line's vector, whether the line is edge or level sensitive, a stored delivery-mode field, and a mask bit. Three more registers give the controller's identity, a fixed version word and an arbitration identity.

Edge lines latch each rising transition as a pending request. Level lines request while high. Once a level message is issued, the entry's in-service flag is set. Further activity on that line merges into the message already sent until an end-of-interrupt naming the entry's vector clears the flag. If the line is still high at that point, the entry fires again. Pending requests go to a one-deep output slot, highest vector first. The slot presents the vector and a level flag on a valid/ready handshake.

Top module: `irq_redir_ctrl`

## Requirements
- R1: The ID register (index 0) resets to zero. A write stores only data bits 27:24. Every other bit reads back as zero whatever was written.
- R2: The version register (index 1) always reads {8'h00, NUM_LINES-1, 8'h00, 8'h20}, and writes to it change nothing.
- R3: The arbitration register (index 2) reads {4'h0, last ID field written, 24'h0}. Writes to index 2 change neither index 2 nor index 0.
- R4: Entry n has a low word at index 0x10+2n with these fields: vector in bits 7:0, delivery mode in bits 10:8, in-service flag in bit 14 (read-only), trigger in bit 15 (1 = level) and mask in bit 16. All other bits read zero. The high word at 0x11+2n, and any index with no register, read zero. After reset every entry reads 32'h0001_0000 (masked, edge, vector 0).
- R5: An unmasked edge entry gives exactly one message per rising transition of its line, with the level flag clear.
- R6: A rising transition while an edge entry is masked is dropped, so unmasking it later produces no message.
- R7: An unmasked level entry whose line is high gives one message with the level flag set and sets its in-service flag. Dropping and raising the line again before end-of-interrupt gives no further message.
- R8: An end-of-interrupt whose vector matches a level entry clears that entry's in-service flag. If the line is still high, a new message follows. An end-of-interrupt with a different vector leaves the flag set.
- R9: A level line held high while its entry is masked gives exactly one message once the entry is unmasked.
- R10: Among requests pending in the same cycle, the highest vector is issued first. Equal vectors are issued in ascending line order. Every request is eventually delivered.
- R11: While msg_valid is high and msg_ready is low, msg_valid, msg_vector and msg_level hold steady.
- R12: A rising edge that arrives in the same cycle the line's earlier pending edge is loaded into the output slot is kept, and it is delivered as a separate message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_idx (combinational) |
| irq_in | input | NUM_LINES | Request lines, synchronous to clk |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message consumer accepts |
| msg_vector | output | 8 | Message vector |
| msg_level | output | 1 | Set when the message comes from a level entry |

## Verification
Two functions can fall in the same cycle on one edge line. The output slot can take that line's pending edge in the same cycle a new rising edge is captured. The bench provokes this by holding msg_ready low while a higher-vector message occupies the slot, then raising msg_ready and the line together, so the reload and the capture meet on one clock edge. It judges the result by the message log, which must show the line's vector twice after the blocking message.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int IDX_W    = 8;
  localparam int DATA_W   = 32;
  localparam int VEC_W    = 8;
  localparam int DMODE_W  = 3;
  localparam int IDX_ID   = 0;
  localparam int IDX_VER  = 1;
  localparam int IDX_ARB  = 2;
  localparam int TBL_BASE = 16;
  localparam logic [7:0] VER_CODE = 8'h20;

  typedef struct packed {
    logic               mask;
    logic               trig;   // 1 = level
    logic [DMODE_W-1:0] dmode;
    logic [VEC_W-1:0]   vec;
  } redir_t;

  localparam redir_t ENTRY_RST = '{mask: 1'b1, trig: 1'b0, dmode: '0, vec: '0};
endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [IDX_W-1:0]              reg_idx,
  input  logic [DATA_W-1:0]             reg_wdata,
  input  logic [NUM_LINES-1:0]          remote,
  output logic [DATA_W-1:0]             reg_rdata,
  output redir_t [NUM_LINES-1:0]        entries,
  output logic [3:0]                    id_field
);
  localparam logic [7:0] TOP_IDX = 8'(NUM_LINES - 1);

  redir_t [NUM_LINES-1:0] ent_q, ent_d;
  logic [3:0]             id_q, id_d;

  // next state
  always_comb begin
    ent_d = ent_q;
    id_d  = id_q;
    if (reg_we) begin
      if (reg_idx == IDX_W'(IDX_ID)) id_d = reg_wdata[27:24];
      for (int n = 0; n < NUM_LINES; n++) begin
        if (reg_idx == IDX_W'(TBL_BASE + 2*n)) begin
          ent_d[n].vec   = reg_wdata[7:0];
          ent_d[n].dmode = reg_wdata[10:8];
          ent_d[n].trig  = reg_wdata[15];
          ent_d[n].mask  = reg_wdata[16];
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
      for (int n = 0; n < NUM_LINES; n++) ent_q[n] <= ENTRY_RST;
    end else begin
      id_q  <= id_d;
      ent_q <= ent_d;
    end
  end

  // read mux; the arbitration word mirrors the stored ID field
  always_comb begin
    reg_rdata = '0;
    if (reg_idx == IDX_W'(IDX_ID) || reg_idx == IDX_W'(IDX_ARB))
      reg_rdata = {4'h0, id_q, 24'h0};
    else if (reg_idx == IDX_W'(IDX_VER))
      reg_rdata = {8'h00, TOP_IDX, 8'h00, VER_CODE};
    for (int n = 0; n < NUM_LINES; n++) begin
      if (reg_idx == IDX_W'(TBL_BASE + 2*n))
        reg_rdata = {15'h0, ent_q[n].mask, ent_q[n].trig, remote[n], 3'b000,
                     ent_q[n].dmode, ent_q[n].vec};
    end
  end

  assign entries  = ent_q;
  assign id_field = id_q;
endmodule

// File: rtl/irq_line_ctl.sv
module irq_line_ctl
  import irq_redir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  redir_t           entry,
  input  logic             load,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic             req,
  output logic             remote
);
  logic prev_q, pend_q, remote_q;
  logic prev_d, pend_d, remote_d;
  logic rise, eoi_hit;

  assign rise    = line & ~prev_q;
  assign eoi_hit = eoi_valid && (eoi_vector == entry.vec);

  always_comb begin
    prev_d = line;
    // a fresh capture wins over the clear from a same-cycle load
    if (entry.trig) pend_d = 1'b0;
    else            pend_d = (pend_q & ~load) | (rise & ~entry.mask);

    if (!entry.trig)  remote_d = 1'b0;
    else if (load)    remote_d = 1'b1;
    else if (eoi_hit) remote_d = 1'b0;
    else              remote_d = remote_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      pend_q   <= 1'b0;
      remote_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      pend_q   <= pend_d;
      remote_q <= remote_d;
    end
  end

  assign req    = entry.trig ? (line & ~entry.mask & ~remote_q) : pend_q;
  assign remote = remote_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0]            req,
  input  redir_t [NUM_LINES-1:0]          entries,
  output logic [NUM_LINES-1:0]            grant,
  output logic                            any,
  output logic [VEC_W-1:0]                win_vec,
  output logic                            win_lvl
);
  always_comb begin
    grant   = '0;
    any     = 1'b0;
    win_vec = '0;
    win_lvl = 1'b0;
    // strict compare keeps the lower line on equal vectors
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i] && (!any || entries[i].vec > win_vec)) begin
        grant    = '0;
        grant[i] = 1'b1;
        any      = 1'b1;
        win_vec  = entries[i].vec;
        win_lvl  = entries[i].trig;
      end
    end
  end
endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [7:0]           reg_idx,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vector,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic                 msg_level
);
  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1_q  <= 1'b1;
      rst_int_n <= rst_s1_q;
    end
  end

  redir_t [NUM_LINES-1:0] entries;
  logic [NUM_LINES-1:0]   remote, req, grant, line_load;
  logic [3:0]             id_field;
  logic                   any, win_lvl, load;
  logic [VEC_W-1:0]       win_vec;

  irq_redir_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .remote(remote), .reg_rdata(reg_rdata),
    .entries(entries), .id_field(id_field)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_ctl u_line (
      .clk(clk), .rst_n(rst_int_n), .line(irq_in[g]), .entry(entries[g]),
      .load(line_load[g]), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .req(req[g]), .remote(remote[g])
    );
  end

  irq_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .req(req), .entries(entries), .grant(grant), .any(any),
    .win_vec(win_vec), .win_lvl(win_lvl)
  );

  // one-deep output slot, refilled in the cycle it drains
  logic             slot_v_q, slot_v_d, slot_lvl_q, slot_lvl_d, slot_en;
  logic [VEC_W-1:0] slot_vec_q, slot_vec_d;

  assign load      = any && (!slot_v_q || msg_ready);
  assign line_load = grant & {NUM_LINES{load}};
  assign slot_en   = load || msg_ready;

  always_comb begin
    slot_v_d   = load;
    slot_vec_d = load ? win_vec : slot_vec_q;
    slot_lvl_d = load ? win_lvl : slot_lvl_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      slot_v_q   <= 1'b0;
      slot_vec_q <= '0;
      slot_lvl_q <= 1'b0;
    end else if (slot_en) begin
      slot_v_q   <= slot_v_d;
      slot_vec_q <= slot_vec_d;
      slot_lvl_q <= slot_lvl_d;
    end
  end

  assign msg_valid  = slot_v_q;
  assign msg_vector = slot_vec_q;
  assign msg_level  = slot_lvl_q;
endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [7:0]           reg_idx,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic [3:0]           id_field,
  input logic [NUM_LINES-1:0] grant,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [7:0]           msg_vector,
  input logic                 msg_level
);
  p_id_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx == 8'd0) |=> id_field == $past(reg_wdata[27:24]));

  p_id_rsvd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 8'd0) |-> (reg_rdata & 32'hF0FF_FFFF) == 32'h0);

  p_ver_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 8'd1) |-> reg_rdata == {8'h00, 8'(NUM_LINES - 1), 8'h00, 8'h20});

  p_arb_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx == 8'd2) |=> $stable(id_field));

  p_grant_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_vector) && $stable(msg_level)));
endmodule

bind irq_redir_ctrl irq_redir_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .reg_we(reg_we), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .id_field(id_field),
  .grant(grant), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_level(msg_level)
);

// File: tb/sim_irq_redir_ctrl.sv
`timescale 1ns/1ps
module sim_irq_redir_ctrl;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [7:0]    reg_idx;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [NL-1:0] irq_in;
  logic          eoi_valid;
  logic [7:0]    eoi_vector;
  logic          msg_valid, msg_ready, msg_level;
  logic [7:0]    msg_vector;

  always #4 clk = ~clk;

  irq_redir_ctrl #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_level(msg_level)
  );

  int checks = 0, fails = 0, log_n = 0;
  bit done = 1'b0;
  logic [7:0] log_vec [256];
  logic       log_lvl [256];

  // message log: a handshake seen at the falling edge completes at the next rising edge
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && log_n < 256) begin
      log_vec[log_n] = msg_vector;
      log_lvl[log_n] = msg_level;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] d);
    @(posedge clk); #1;
    reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  task automatic set_entry(input int n, input logic [7:0] vec, input bit lvl,
                           input bit msk);
    wr(8'(16 + 2*n), {15'h0, msk, lvl, 7'h0, vec});
  endtask

  task automatic eoi(input logic [7:0] v);
    @(posedge clk); #1;
    eoi_valid = 1'b1; eoi_vector = v;
    @(posedge clk); #1;
    eoi_valid = 1'b0;
  endtask

  task automatic clear_all();
    irq_in = '0;
    for (int n = 0; n < NL; n++) set_entry(n, 8'h00, 1'b0, 1'b1);
    cyc(3);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    rst_n = 1'b0; reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
    irq_in = '0; eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // reset state
    chk(msg_valid == 1'b0, "R4 reset msg_valid", 32'(msg_valid), 0);
    rd(8'd0, d); chk(d == 0, "R1 reset id", d, 0);
    for (int n = 0; n < NL; n++) begin
      rd(8'(16 + 2*n), d); chk(d == 32'h0001_0000, "R4 reset entry", d, 32'h0001_0000);
    end

    // R1 / R3: sweep the writable nibble with garbage around it
    for (int v = 0; v < 16; v++) begin
      wr(8'd0, {4'hA, 4'(v), 24'h5A5A5A});
      rd(8'd0, d); chk(d == {8'(v), 24'h0}, "R1 id field", d, {8'(v), 24'h0});
      rd(8'd2, d); chk(d == {8'(v), 24'h0}, "R3 arb follows id", d, {8'(v), 24'h0});
    end
    wr(8'd2, 32'h0000_0000);
    rd(8'd2, d); chk(d == 32'h0F00_0000, "R3 arb write ignored", d, 32'h0F00_0000);
    rd(8'd0, d); chk(d == 32'h0F00_0000, "R3 id unchanged", d, 32'h0F00_0000);

    // R2
    wr(8'd1, 32'hFFFF_FFFF);
    rd(8'd1, d); chk(d == {16'h0000 | 16'(NL - 1) << 8 >> 8, 8'h00, 8'h20} && d == 32'h0007_0020,
                     "R2 version", d, 32'h0007_0020);

    // R4: field sweep over all entries
    for (int n = 0; n < NL; n++) begin
      wr(8'(16 + 2*n), 32'hFFFF_7800 | (32'(n % 8) << 8) | 32'(8'h40 + n));
      rd(8'(16 + 2*n), d);
      chk(d == (32'h0001_0000 | (32'(n % 8) << 8) | 32'(8'h40 + n)), "R4 entry fields", d,
          32'h0001_0000 | (32'(n % 8) << 8) | 32'(8'h40 + n));
      wr(8'(17 + 2*n), 32'hFFFF_FFFF);
      rd(8'(17 + 2*n), d); chk(d == 0, "R4 high word", d, 0);
    end
    rd(8'(16 + 2*NL), d); chk(d == 0, "R4 unmapped", d, 0);
    rd(8'd3, d); chk(d == 0, "R4 unmapped low", d, 0);
    clear_all();

    // R5: k separate pulses give k messages
    set_entry(0, 8'h30, 1'b0, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      base = log_n;
      for (int p = 0; p < k; p++) begin
        irq_in[0] = 1'b1; cyc(2); irq_in[0] = 1'b0; cyc(2);
      end
      cyc(4);
      chk(log_n - base == k, "R5 edge count", 32'(log_n - base), 32'(k));
      chk(log_vec[base] == 8'h30 && log_lvl[base] == 1'b0, "R5 edge vector/flag",
          {log_lvl[base], log_vec[base]}, 32'h030);
    end
    base = log_n;
    irq_in[0] = 1'b1; cyc(8); irq_in[0] = 1'b0; cyc(4);
    chk(log_n - base == 1, "R5 held line one message", 32'(log_n - base), 1);

    // R6
    set_entry(0, 8'h30, 1'b0, 1'b1);
    base = log_n;
    irq_in[0] = 1'b1; cyc(2); irq_in[0] = 1'b0; cyc(2);
    set_entry(0, 8'h30, 1'b0, 1'b0);
    cyc(6);
    chk(log_n == base, "R6 masked edge dropped", 32'(log_n - base), 0);
    clear_all();

    // R7
    set_entry(1, 8'h50, 1'b1, 1'b0);
    base = log_n;
    irq_in[1] = 1'b1; cyc(4);
    chk(log_n - base == 1, "R7 level one message", 32'(log_n - base), 1);
    chk(log_vec[base] == 8'h50 && log_lvl[base] == 1'b1, "R7 level flag",
        {log_lvl[base], log_vec[base]}, 32'h150);
    rd(8'd18, d); chk(d[14] == 1'b1, "R7 in-service set", 32'(d[14]), 1);
    for (int t = 0; t < 2; t++) begin
      irq_in[1] = 1'b0; cyc(2); irq_in[1] = 1'b1; cyc(2);
    end
    cyc(4);
    chk(log_n - base == 1, "R7 coalesced", 32'(log_n - base), 1);

    // R8
    eoi(8'h50); cyc(4);
    chk(log_n - base == 2, "R8 refire after eoi", 32'(log_n - base), 2);
    eoi(8'h51); cyc(4);
    rd(8'd18, d); chk(d[14] == 1'b1, "R8 other vector ignored", 32'(d[14]), 1);
    chk(log_n - base == 2, "R8 no message on other vector", 32'(log_n - base), 2);
    irq_in[1] = 1'b0; cyc(2);
    eoi(8'h50); cyc(4);
    rd(8'd18, d); chk(d[14] == 1'b0, "R8 flag cleared", 32'(d[14]), 0);
    chk(log_n - base == 2, "R8 low line no refire", 32'(log_n - base), 2);
    clear_all();

    // R9
    set_entry(2, 8'h60, 1'b1, 1'b1);
    base = log_n;
    irq_in[2] = 1'b1; cyc(6);
    chk(log_n == base, "R9 masked level quiet", 32'(log_n - base), 0);
    set_entry(2, 8'h60, 1'b1, 1'b0); cyc(6);
    chk(log_n - base == 1, "R9 unmask delivers", 32'(log_n - base), 1);
    chk(log_vec[base] == 8'h60, "R9 vector", 32'(log_vec[base]), 32'h60);
    clear_all();

    // R10 / R11: simultaneous edges, two vector patterns
    for (int pat = 0; pat < 2; pat++) begin
      logic [7:0] vv [4];
      bit taken [4];
      for (int i = 0; i < 4; i++) begin
        vv[i] = (pat == 0) ? 8'(8'h70 + 8'h10 * ((i * 3) % 4)) : 8'(8'h90 - 8'h10 * (i % 2));
        taken[i] = 1'b0;
        set_entry(i, vv[i], 1'b0, 1'b0);
      end
      msg_ready = 1'b0;
      base = log_n;
      irq_in[3:0] = 4'hF; cyc(1); irq_in[3:0] = 4'h0; cyc(3);
      for (int t = 0; t < 3; t++) begin
        logic [7:0] v0;
        v0 = msg_vector;
        cyc(1);
        chk(msg_valid && msg_vector == v0, "R11 hold while stalled", 32'(msg_vector), 32'(v0));
      end
      msg_ready = 1'b1; cyc(8);
      chk(log_n - base == 4, "R10 all delivered", 32'(log_n - base), 4);
      for (int p = 0; p < 4; p++) begin
        int best;
        best = -1;
        for (int i = 0; i < 4; i++)
          if (!taken[i] && (best < 0 || vv[i] > vv[best])) best = i;
        taken[best] = 1'b1;
        chk(log_vec[base + p] == vv[best], "R10 order", 32'(log_vec[base + p]), 32'(vv[best]));
      end
    end
    clear_all();

    // R12: reload and fresh capture on one edge
    set_entry(3, 8'hF0, 1'b0, 1'b0);
    set_entry(0, 8'h31, 1'b0, 1'b0);
    msg_ready = 1'b0;
    base = log_n;
    irq_in[3] = 1'b1; cyc(1); irq_in[3] = 1'b0; cyc(3);
    irq_in[0] = 1'b1; cyc(1); irq_in[0] = 1'b0; cyc(3);
    irq_in[0] = 1'b1; msg_ready = 1'b1; cyc(1);
    irq_in[0] = 1'b0; cyc(6);
    chk(log_n - base == 3, "R12 both edges kept", 32'(log_n - base), 3);
    chk(log_vec[base] == 8'hF0 && log_vec[base + 1] == 8'h31 && log_vec[base + 2] == 8'h31,
        "R12 sequence", {8'h0, log_vec[base], log_vec[base + 1], log_vec[base + 2]},
        32'h00F0_3131);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule